// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sits between a CPU core and an external memory bus of the classic multiplexed kind. The bus has one 8-bit port that carries the low address byte and then data, an 8-bit high-address port, an address latch enable, separate active-low strobes for program fetch, data read and data write, and one more active-low read strobe meant for a single memory that holds both program and data.

The core hands over one request at a time through a valid/ready handshake. A request is a program fetch with a 16-bit program counter, or a data read or write addressed either by a 16-bit data pointer or by an 8-bit register-indirect address. The block decides whether a fetch goes off-chip, runs each external cycle period by period, and pulses a done flag with the byte that was read. The high-address port takes the upper program-counter byte on fetches, the upper pointer byte on pointer-addressed data accesses, and the port-2 latch value on register-indirect accesses. That latch is an input here, and the block never changes it.

Top module: `xbus_seq`

## Requirements
- R1: After reset, and while no cycle runs: ale=0, psen_n=1, rd_n=1, wr_n=1, shared_rd_n=1, ad_oe=0, done=0 and req_ready=1.
- R2: A fetch (req_kind=2'b00) goes off-chip when ea_n=0 or req_pc>16'h3FFF. Otherwise it finishes as an internal fetch: one period with no strobe, then done=1 with done_ext=0 and done_data=0.
- R3: An external fetch lasts 3 periods. In period 0, ale=1 and all strobes are high. In periods 1 and 2, ale=0 and psen_n=0. rd_n and wr_n stay high throughout.
- R4: A data read (req_kind=2'b01) lasts 6 periods. ale=1 only in period 0, rd_n=0 in periods 2 to 5, and psen_n and wr_n stay high.
- R5: A data write (req_kind=2'b10) lasts 6 periods with ad_oe=1 throughout. ad_out carries the write byte in periods 1 to 5, and wr_n=0 only in periods 2 to 4. The data is therefore set up before WR goes low and held after it rises.
- R6: In period 0 of every external cycle, ad_out carries the low address byte. For the whole cycle, a_hi carries req_pc[15:8] on a fetch, req_dptr[15:8] when req_ind=0 on a data access, and p2_latch when req_ind=1. With req_ind=1, the low address is req_ri.
- R7: The byte on ad_in at the end of the last period of an external fetch or read is captured while the strobe is still low. It appears on done_data together with done=1 and done_ext=1 in the cycle after the last period.
- R8: At every cycle, shared_rd_n equals psen_n AND rd_n.
- R9: One request at a time: req_ready=0 for the whole of a running cycle, and done is a single-cycle pulse.
- R10: During external fetches and reads, ad_oe=0 from period 1 on, so the port is released for the memory to drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write (11 handled as fetch) |
| req_ind | input | 1 | Data access: 0 pointer-addressed, 1 register-indirect |
| req_pc | input | 16 | Program counter for fetches |
| req_dptr | input | 16 | Data pointer for pointer-addressed accesses |
| req_ri | input | 8 | Register-indirect low address |
| req_wdata | input | 8 | Byte to write |
| p2_latch | input | 8 | Port-2 latch value, high address for register-indirect accesses |
| ea_n | input | 1 | External-access select, active low |
| ad_in | input | 8 | Multiplexed port input |
| ad_out | output | 8 | Multiplexed port output |
| ad_oe | output | 1 | Multiplexed port output enable |
| a_hi | output | 8 | High-address port |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| shared_rd_n | output | 1 | Combined read strobe, active low |
| done | output | 1 | Request finished (one cycle) |
| done_ext | output | 1 | Finished request used the external bus |
| done_data | output | 8 | Byte read, valid with done |

## Verification
Every pin is registered, so the pin values of period 0 appear in the cycle right after the accepting edge. Period p shows p cycles later, and done comes one cycle after the last period: 2 cycles after the accept for an internal fetch, 4 for an external fetch and 7 for a data access. Each scenario task drives inputs on a falling edge and then samples every pin on each following falling edge, one period at a time, against a per-period table built from the requirements. The memory model drives ad_in only while a read strobe is low, so a byte captured after the strobe's release would read back as zero.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int PH_W = 4;
    typedef logic [PH_W-1:0] ph_t;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'b00,
        ACC_DREAD  = 2'b01,
        ACC_DWRITE = 2'b10
    } acc_e;

    typedef struct packed {
        acc_e       kind;
        logic       ext;
        logic [7:0] a_lo;
        logic [7:0] a_hi;
        logic [7:0] wdata;
        ph_t        last;
    } cyc_t;

    function automatic acc_e to_kind(input logic [1:0] code);
        case (code)
            2'b01:   return ACC_DREAD;
            2'b10:   return ACC_DWRITE;
            default: return ACC_FETCH;
        endcase
    endfunction

    function automatic logic fetch_goes_out(input logic        ea_n,
                                            input logic [15:0] pc,
                                            input logic [15:0] top);
        return (!ea_n) || (pc > top);
    endfunction

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int          FETCH_PERIODS = 3,
    parameter int          DATA_PERIODS  = 6,
    parameter logic [15:0] INT_TOP       = 16'h3FFF
) (
    input  logic [1:0]  kind_code,
    input  logic        ind,
    input  logic [15:0] pc,
    input  logic [15:0] dptr,
    input  logic [7:0]  ri,
    input  logic [7:0]  wdata,
    input  logic [7:0]  p2_latch,
    input  logic        ea_n,
    output cyc_t        cyc
);
    localparam ph_t FETCH_LAST = ph_t'(FETCH_PERIODS - 1);
    localparam ph_t DATA_LAST  = ph_t'(DATA_PERIODS - 1);

    always_comb begin
        cyc.kind  = to_kind(kind_code);
        cyc.wdata = wdata;
        if (cyc.kind == ACC_FETCH) begin
            cyc.ext  = fetch_goes_out(ea_n, pc, INT_TOP);
            cyc.a_lo = pc[7:0];
            cyc.a_hi = pc[15:8];
            cyc.last = cyc.ext ? FETCH_LAST : ph_t'(0);
        end else begin
            cyc.ext  = 1'b1;
            cyc.a_lo = ind ? ri       : dptr[7:0];
            cyc.a_hi = ind ? p2_latch : dptr[15:8];
            cyc.last = DATA_LAST;
        end
    end
endmodule

// File: rtl/xbus_phase.sv
module xbus_phase
    import xbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  cyc_t cyc_in,
    output logic busy,
    output logic fin,
    output cyc_t cur,
    output logic nxt_busy,
    output ph_t  nxt_ph,
    output cyc_t nxt_cyc
);
    ph_t ph;

    assign fin = busy && (ph == cur.last);

    always_comb begin
        nxt_busy = busy;
        nxt_ph   = ph;
        nxt_cyc  = cur;
        if (busy) begin
            if (fin) begin
                nxt_busy = 1'b0;
                nxt_ph   = '0;
            end else begin
                nxt_ph = ph + ph_t'(1);
            end
        end else if (accept) begin
            nxt_busy = 1'b1;
            nxt_ph   = '0;
            nxt_cyc  = cyc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ph   <= '0;
            cur  <= cyc_t'('0);
        end else begin
            busy <= nxt_busy;
            ph   <= nxt_ph;
            cur  <= nxt_cyc;
        end
    end

    p_ph_bound_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ph <= cur.last));
    p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !fin) |=> busy && $stable(cur));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int DATA_PERIODS = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       nxt_busy,
    input  ph_t        nxt_ph,
    input  cyc_t       nxt_cyc,
    input  logic       fin,
    input  cyc_t       cur,
    input  logic [7:0] ad_in,
    output logic [7:0] ad_out,
    output logic       ad_oe,
    output logic [7:0] a_hi,
    output logic       ale,
    output logic       psen_n,
    output logic       rd_n,
    output logic       wr_n,
    output logic       shared_rd_n,
    output logic       done,
    output logic       done_ext,
    output logic [7:0] done_data
);
    localparam ph_t STROBE_FIRST = ph_t'(2);
    localparam ph_t WR_LAST      = ph_t'(DATA_PERIODS - 2);

    logic       act, s_ale, s_psen, s_rd, s_wr, s_oe, cap;
    logic [7:0] s_ad, s_hi;

    always_comb begin
        act    = nxt_busy && nxt_cyc.ext;
        s_ale  = act && (nxt_ph == '0);
        s_psen = !(act && nxt_cyc.kind == ACC_FETCH && nxt_ph != '0);
        s_rd   = !(act && nxt_cyc.kind == ACC_DREAD && nxt_ph >= STROBE_FIRST);
        s_wr   = !(act && nxt_cyc.kind == ACC_DWRITE &&
                   nxt_ph >= STROBE_FIRST && nxt_ph <= WR_LAST);
        s_oe   = act && (nxt_ph == '0 || nxt_cyc.kind == ACC_DWRITE);
        if (!s_oe)
            s_ad = 8'h00;
        else if (nxt_ph == '0)
            s_ad = nxt_cyc.a_lo;
        else
            s_ad = nxt_cyc.wdata;
        s_hi   = act ? nxt_cyc.a_hi : a_hi;
        cap    = fin && cur.ext && (cur.kind != ACC_DWRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ale         <= 1'b0;
            psen_n      <= 1'b1;
            rd_n        <= 1'b1;
            wr_n        <= 1'b1;
            shared_rd_n <= 1'b1;
            ad_oe       <= 1'b0;
            ad_out      <= 8'h00;
            a_hi        <= 8'h00;
            done        <= 1'b0;
            done_ext    <= 1'b0;
            done_data   <= 8'h00;
        end else begin
            ale         <= s_ale;
            psen_n      <= s_psen;
            rd_n        <= s_rd;
            wr_n        <= s_wr;
            shared_rd_n <= s_psen & s_rd;
            ad_oe       <= s_oe;
            ad_out      <= s_ad;
            a_hi        <= s_hi;
            done        <= fin;
            done_ext    <= fin && cur.ext;
            done_data   <= cap ? ad_in : 8'h00;
        end
    end

    p_shared_and_r8: assert property (@(posedge clk) disable iff (rst)
        shared_rd_n == (psen_n & rd_n));
    p_ale_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        ale |-> (psen_n && rd_n && wr_n && ad_oe));
    p_wr_driven_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (ad_oe && $stable(ad_out)));
    p_wr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> ad_oe);
    p_read_released_r10: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !ad_oe);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int          FETCH_PERIODS = 3,
    parameter int          DATA_PERIODS  = 6,
    parameter logic [15:0] INT_TOP       = 16'h3FFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic        req_ind,
    input  logic [15:0] req_pc,
    input  logic [15:0] req_dptr,
    input  logic [7:0]  req_ri,
    input  logic [7:0]  req_wdata,
    input  logic [7:0]  p2_latch,
    input  logic        ea_n,
    input  logic [7:0]  ad_in,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    output logic [7:0]  a_hi,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic        shared_rd_n,
    output logic        done,
    output logic        done_ext,
    output logic [7:0]  done_data
);
    cyc_t dec_cyc, cur, nxt_cyc;
    logic busy, fin, nxt_busy;
    ph_t  nxt_ph;

    assign req_ready = !busy;

    xbus_decode #(
        .FETCH_PERIODS(FETCH_PERIODS),
        .DATA_PERIODS (DATA_PERIODS),
        .INT_TOP      (INT_TOP)
    ) u_dec (
        .kind_code(req_kind), .ind(req_ind), .pc(req_pc), .dptr(req_dptr),
        .ri(req_ri), .wdata(req_wdata), .p2_latch(p2_latch), .ea_n(ea_n),
        .cyc(dec_cyc)
    );

    xbus_phase u_phase (
        .clk(clk), .rst(rst), .accept(req_valid && req_ready),
        .cyc_in(dec_cyc), .busy(busy), .fin(fin), .cur(cur),
        .nxt_busy(nxt_busy), .nxt_ph(nxt_ph), .nxt_cyc(nxt_cyc)
    );

    xbus_pins #(.DATA_PERIODS(DATA_PERIODS)) u_pins (
        .clk(clk), .rst(rst), .nxt_busy(nxt_busy), .nxt_ph(nxt_ph),
        .nxt_cyc(nxt_cyc), .fin(fin), .cur(cur), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .shared_rd_n(shared_rd_n), .done(done), .done_ext(done_ext),
        .done_data(done_data)
    );

    p_internal_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !done_ext) |-> (psen_n && done_data == 8'h00));
endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_ind, ea_n;
    logic [1:0]  req_kind;
    logic [15:0] req_pc, req_dptr;
    logic [7:0]  req_ri, req_wdata, p2_latch, ad_in, ad_out, a_hi, done_data;
    logic        ad_oe, ale, psen_n, rd_n, wr_n, shared_rd_n, done, done_ext;
    logic [7:0]  mem_byte;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    // memory model drives the port only while a read strobe is low
    assign ad_in = (!psen_n || !rd_n) ? mem_byte : 8'h00;

    xbus_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_ind(req_ind), .req_pc(req_pc),
        .req_dptr(req_dptr), .req_ri(req_ri), .req_wdata(req_wdata),
        .p2_latch(p2_latch), .ea_n(ea_n), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .shared_rd_n(shared_rd_n), .done(done),
        .done_ext(done_ext), .done_data(done_data)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [6:0] pins_now();
        return {ale, psen_n, rd_n, wr_n, ad_oe, shared_rd_n, req_ready};
    endfunction

    // kind: 0 fetch, 1 read, 2 write; len in periods; ext = off-chip
    task automatic run_cycle(input string tag, input logic [1:0] kind,
                             input logic ext, input int len,
                             input logic [7:0] lo, input logic [7:0] hi,
                             input logic [7:0] wd, input logic [7:0] rbyte);
        logic [6:0] exp_p;
        logic       e_ale, e_ps, e_rd, e_wr, e_oe;
        @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        for (int p = 0; p < len; p++) begin
            if (p > 0) @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            e_ale = ext && p == 0;
            e_ps  = !(ext && kind == 2'd0 && p >= 1);
            e_rd  = !(ext && kind == 2'd1 && p >= 2);
            e_wr  = !(ext && kind == 2'd2 && p >= 2 && p <= 4);
            e_oe  = ext && (p == 0 || kind == 2'd2);
            exp_p = {e_ale, e_ps, e_rd, e_wr, e_oe, e_ps & e_rd, 1'b0};
            // R3 R4 R5 R8 R9 R10: per-period pin pattern
            chk(pins_now() == exp_p, {tag, " R3/R4/R5/R8/R9/R10 pins"},
                32'(pins_now()), 32'(exp_p));
            if (ext) begin
                chk(a_hi == hi, {tag, " R6 high address"}, 32'(a_hi), 32'(hi));
                if (p == 0)
                    chk(ad_out == lo, {tag, " R6 low address"}, 32'(ad_out), 32'(lo));
                else if (kind == 2'd2)
                    chk(ad_out == wd, {tag, " R5 write data"}, 32'(ad_out), 32'(wd));
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(done && done_ext == ext && done_data == rbyte,
            {tag, " R7 done/data"}, {22'd0, done, done_ext, done_data},
            {22'd0, 1'b1, ext, rbyte});
        chk(pins_now() == 7'b0111011, {tag, " R1 idle after cycle"},
            32'(pins_now()), 32'h3B);
        @(posedge clk);
        @(negedge clk);
        chk(!done, {tag, " R9 done single pulse"}, 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        chk(pins_now() == 7'b0111011 && !done, "R1 reset state",
            32'({pins_now(), done}), 32'h76);
    endtask

    task automatic t_fetch(input logic [15:0] pc, input logic ea,
                           input logic ext, input logic [7:0] b);
        req_kind = 2'b00; req_pc = pc; ea_n = ea; mem_byte = b;
        // R2 off-chip decision, R3 fetch timing, R7 capture
        run_cycle($sformatf("R2 fetch pc=%h ea_n=%b", pc, ea), 2'd0, ext,
                  ext ? 3 : 1, pc[7:0], pc[15:8], 8'h00, ext ? b : 8'h00);
    endtask

    task automatic t_read(input logic ind, input logic [15:0] dp,
                          input logic [7:0] ri, input logic [7:0] p2,
                          input logic [7:0] b);
        req_kind = 2'b01; req_ind = ind; req_dptr = dp; req_ri = ri;
        p2_latch = p2; mem_byte = b;
        run_cycle($sformatf("R4 read ind=%b", ind), 2'd1, 1'b1, 6,
                  ind ? ri : dp[7:0], ind ? p2 : dp[15:8], 8'h00, b);
    endtask

    task automatic t_write(input logic ind, input logic [15:0] dp,
                           input logic [7:0] ri, input logic [7:0] p2,
                           input logic [7:0] wd);
        req_kind = 2'b10; req_ind = ind; req_dptr = dp; req_ri = ri;
        p2_latch = p2; req_wdata = wd; mem_byte = 8'hFF;
        run_cycle($sformatf("R5 write ind=%b", ind), 2'd2, 1'b1, 6,
                  ind ? ri : dp[7:0], ind ? p2 : dp[15:8], wd, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired got=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'b00; req_ind = 1'b0;
        req_pc = '0; req_dptr = '0; req_ri = '0; req_wdata = '0;
        p2_latch = '0; ea_n = 1'b1; mem_byte = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fetch(16'h1234, 1'b1, 1'b0, 8'h11);
        t_fetch(16'h3FFF, 1'b1, 1'b0, 8'h22);
        t_fetch(16'h4000, 1'b1, 1'b1, 8'hA5);
        t_fetch(16'h0010, 1'b0, 1'b1, 8'h3C);
        t_read(1'b0, 16'h8123, 8'h00, 8'h55, 8'h5A);
        t_read(1'b1, 16'hFFFF, 8'h44, 8'h9E, 8'hC3);
        t_write(1'b0, 16'hBEEF, 8'h00, 8'h33, 8'h77);
        t_write(1'b1, 16'h0000, 8'h12, 8'h01, 8'hE1);
        chk(p2_latch == 8'h01, "R6 port-2 latch untouched", 32'(p2_latch), 32'h01);
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule